// File: doc/BRIEF.md
# Audio Converter Control Register Slave

This block is the control-register end of an audio converter's serial management link. An external master frames each access with an active-low chip select. Inside the frame it sends a direction bit, a 7-bit register address and 8 data bits. A write updates the addressed register once the frame completes. A read returns that register's contents on the serial data output during the data phase. The register file holds the converter's power-up enables, right-channel line gains, mixer routing, data format options and reset controls. Each register drives dedicated field outputs toward the analog and digital datapath.

The serial lines are treated as slow asynchronous inputs. They are synchronised into the system clock, and edges of the serial clock are found by comparing successive synchronised samples. Because of this, every flop in the block runs on one clock. The output enable tells the pad when the slave owns the data-out line.

Top module: `codec_spi_regs`

## Requirements
- R1: A frame is 16 serial clocks while chip select is low. It carries a direction bit (0 = write, 1 = read), then the address MSB first, then data MSB first. A write frame stores the data into the addressed register.
- R2: Input bits are captured on falling serial clock edges. The data output changes only on rising edges. Before the rising edge that follows the eighth falling edge of a frame, the output is still 0.
- R3: In a read frame, the eight rising edges after the address shift out the register contents, MSB first.
- R4: After reset, the registers read as follows: 00h = 00h, 02h = 05h, 06h = 00h, 08h = 00h, 0Ah = 02h, 10h = 00h.
- R5: Each register implements only its own width: 00h has 8 bits, 02h has 5, 06h has 6, 08h has 6, 0Ah has 6 and 10h has 3. Written bits above that width are dropped and read as 0.
- R6: An address outside the map reads 0, and a write to it changes no register.
- R7: If chip select rises before the 16th falling edge, the frame is dropped and no register is written.
- R8: While chip select is high the output enable is 0 and the data output is 0.
- R9: Register fields appear on the outputs as follows:
  - 00h drives the eight power enables (1 = powered up).
  - 02h drives the line-in gain and 06h the line-out gain.
  - 08h drives the mixer controls: bit 5 inverts right, bit 4 inverts left, bits 3:0 are the four input enables.
  - 0Ah drives the format controls: bits 5:4 format select, bit 3 dither, bit 2 de-emphasis, bits 1:0 word length.
  - 10h drives the reset controls: bit 2 mask, bit 1 filter reset (active low), bit 0 converter reset (active low).
- R10: Serial clocks beyond the 16th in one frame are ignored. The register keeps the data from the first 8 data bits.
- R11: A read frame leaves the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data from the master |
| spi_sdo | output | 1 | Serial read data |
| spi_sdo_oe | output | 1 | Pad enable for spi_sdo; 0 means high impedance |
| pwr_en | output | 8 | Power-up enables (register 00h) |
| lin_gain_r | output | 5 | Right line-in gain (register 02h) |
| lout_gain_r | output | 6 | Right line-out gain (register 06h) |
| mix_ctrl | output | 6 | Mixer invert and input enables (register 08h) |
| fmt_ctrl | output | 6 | Format, dither, de-emphasis, word length (register 0Ah) |
| rst_ctrl | output | 3 | Mask, filter reset, converter reset (register 10h) |

## Verification
The assertions assume that each serial clock phase lasts several system clocks, longer than the synchroniser depth plus one. They also assume the data input is steady across each falling edge, and that chip select changes only while the serial clock is high. Under these conditions every edge is seen exactly once and in order. The stimulus holds each serial clock phase for eight system clocks. It changes data and chip select only during the high phase, with the inputs driven on the falling system clock edge.

// File: rtl/codec_spi_pkg.sv
package codec_spi_pkg;

   localparam int MAP_ADDR_W = 7;
   localparam int MAP_DATA_W = 8;
   localparam int NUM_REGS   = 6;

   typedef struct packed {
      logic [MAP_ADDR_W-1:0] addr;
      logic [MAP_DATA_W-1:0] mask;
      logic [MAP_DATA_W-1:0] init;
   } reg_desc_t;

   // Register map: address, implemented bits, value after reset
   function automatic reg_desc_t reg_desc(input int idx);
      reg_desc_t d;
      case (idx)
         0:       d = '{addr: 7'h00, mask: 8'hFF, init: 8'h00}; // power enables
         1:       d = '{addr: 7'h02, mask: 8'h1F, init: 8'h05}; // line-in gain R
         2:       d = '{addr: 7'h06, mask: 8'h3F, init: 8'h00}; // line-out gain R
         3:       d = '{addr: 7'h08, mask: 8'h3F, init: 8'h00}; // mixer
         4:       d = '{addr: 7'h0A, mask: 8'h3F, init: 8'h02}; // format
         default: d = '{addr: 7'h10, mask: 8'h07, init: 8'h00}; // resets
      endcase
      return d;
   endfunction

endpackage

// File: rtl/codec_spi_sync.sv
module codec_spi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("codec_spi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/codec_spi_frame.sv
module codec_spi_frame #(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              sdo,
   output logic              sdo_oe
);

   localparam int HDR_BITS   = 1 + ADDR_W;
   localparam int FRAME_BITS = HDR_BITS + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);
   localparam int SH_W       = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
   localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_BITS - 1);
   localparam logic [CNT_W-1:0] CNT_HDR      = CNT_W'(HDR_BITS);
   localparam logic [CNT_W-1:0] CNT_LAST     = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_BITS);
   // reset value per synchronised line: {sclk, cs_n, sdi}
   localparam logic [2:0] SYNC_RST = 3'b110;

   if (ADDR_W < 2 || DATA_W < 2) begin : g_bad_width
      $error("codec_spi_frame: ADDR_W and DATA_W must be at least 2");
   end

   logic [2:0] raw_in, sync_out;
   assign raw_in = {sclk, cs_n, sdi};

   for (genvar g = 0; g < 3; g++) begin : g_sync
      codec_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (raw_in[g]),
         .q     (sync_out[g])
      );
   end

   logic sclk_s, cs_s, sdi_s;
   assign sclk_s = sync_out[2];
   assign cs_s   = sync_out[1];
   assign sdi_s  = sync_out[0];

   logic sclk_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b1;
      else        sclk_d <= sclk_s;
   end

   logic fall, rise;
   assign fall = sclk_d & ~sclk_s & ~cs_s;
   assign rise = ~sclk_d & sclk_s & ~cs_s;

   logic [CNT_W-1:0]  cnt_q;
   logic [SH_W-1:0]   in_sh;
   logic              hdr_rw_q;
   logic [ADDR_W-1:0] hdr_addr_q;
   logic [DATA_W-1:0] out_sh;
   logic              sdo_q, oe_q;
   logic              take;

   assign take    = fall && (cnt_q < CNT_FULL);
   assign rd_addr = {in_sh[ADDR_W-2:0], sdi_s};

   // bit counter and input shifter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         in_sh <= '0;
      end else if (cs_s) begin
         cnt_q <= '0;
      end else if (take) begin
         cnt_q <= cnt_q + 1'b1;
         in_sh <= {in_sh[SH_W-2:0], sdi_s};
      end
   end

   // header capture and commit of a complete write frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_rw_q   <= 1'b0;
         hdr_addr_q <= '0;
         wr_stb     <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (!cs_s && take && cnt_q == CNT_HDR_LAST) begin
            hdr_rw_q   <= in_sh[ADDR_W-1];
            hdr_addr_q <= rd_addr;
         end
         if (!cs_s && take && cnt_q == CNT_LAST && !hdr_rw_q) begin
            wr_stb  <= 1'b1;
            wr_addr <= hdr_addr_q;
            wr_data <= {in_sh[DATA_W-2:0], sdi_s};
         end
      end
   end

   // read shifter: loaded with the header, advanced on rising edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_sh <= '0;
         sdo_q  <= 1'b0;
         oe_q   <= 1'b0;
      end else begin
         oe_q <= ~cs_s;
         if (cs_s) begin
            out_sh <= '0;
            sdo_q  <= 1'b0;
         end else begin
            if (take && cnt_q == CNT_HDR_LAST)
               out_sh <= in_sh[ADDR_W-1] ? rd_data : '0;
            else if (rise && cnt_q >= CNT_HDR && cnt_q <= CNT_LAST) begin
               sdo_q  <= out_sh[DATA_W-1];
               out_sh <= {out_sh[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign sdo    = sdo_q;
   assign sdo_oe = oe_q;

   // R1
   wr_full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (cnt_q == CNT_FULL));

   // R10
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R7
   cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (cnt_q == '0));

endmodule

// File: rtl/codec_spi_regfile.sv
module codec_spi_regfile
   import codec_spi_pkg::*;
(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_stb,
   input  logic [MAP_ADDR_W-1:0]          wr_addr,
   input  logic [MAP_DATA_W-1:0]          wr_data,
   input  logic [MAP_ADDR_W-1:0]          rd_addr,
   output logic [MAP_DATA_W-1:0]          rd_data,
   output logic [NUM_REGS*MAP_DATA_W-1:0] regs_flat
);

   logic [MAP_DATA_W-1:0] reg_q   [NUM_REGS];
   logic [MAP_DATA_W-1:0] rd_term [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam reg_desc_t DESC = reg_desc(i);

      if ((DESC.init & ~DESC.mask) != '0) begin : g_bad_init
         $error("codec_spi_regfile: reset value exceeds register width");
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            reg_q[i] <= DESC.init;
         else if (wr_stb && wr_addr == DESC.addr)
            reg_q[i] <= wr_data & DESC.mask;
      end

      assign rd_term[i] = (rd_addr == DESC.addr) ? reg_q[i] : '0;
      assign regs_flat[i*MAP_DATA_W +: MAP_DATA_W] = reg_q[i];

      // R11
      reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_stb |=> $stable(reg_q[i]));
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_REGS; k++)
         rd_data = rd_data | rd_term[k];
   end

endmodule

// File: rtl/codec_spi_regs.sv
module codec_spi_regs
   import codec_spi_pkg::*;
#(
   parameter int ADDR_W      = MAP_ADDR_W,
   parameter int DATA_W      = MAP_DATA_W,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sclk,
   input  logic       spi_cs_n,
   input  logic       spi_sdi,
   output logic       spi_sdo,
   output logic       spi_sdo_oe,
   output logic [7:0] pwr_en,
   output logic [4:0] lin_gain_r,
   output logic [5:0] lout_gain_r,
   output logic [5:0] mix_ctrl,
   output logic [5:0] fmt_ctrl,
   output logic [2:0] rst_ctrl
);

   if (ADDR_W != MAP_ADDR_W || DATA_W != MAP_DATA_W) begin : g_bad_map
      $error("codec_spi_regs: frame widths must match the register map");
   end

   logic [ADDR_W-1:0]              rd_addr, wr_addr;
   logic [DATA_W-1:0]              rd_data, wr_data;
   logic                           wr_stb;
   logic [NUM_REGS*MAP_DATA_W-1:0] regs_flat;

   codec_spi_frame #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk    (spi_sclk),
      .cs_n    (spi_cs_n),
      .sdi     (spi_sdi),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sdo     (spi_sdo),
      .sdo_oe  (spi_sdo_oe)
   );

   codec_spi_regfile u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .regs_flat (regs_flat)
   );

   assign pwr_en      = regs_flat[0*MAP_DATA_W +: 8];
   assign lin_gain_r  = regs_flat[1*MAP_DATA_W +: 5];
   assign lout_gain_r = regs_flat[2*MAP_DATA_W +: 6];
   assign mix_ctrl    = regs_flat[3*MAP_DATA_W +: 6];
   assign fmt_ctrl    = regs_flat[4*MAP_DATA_W +: 6];
   assign rst_ctrl    = regs_flat[5*MAP_DATA_W +: 3];

   // R8
   sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_sdo_oe |-> !spi_sdo);

endmodule

// File: tb/codec_spi_regs_bench.sv
module codec_spi_regs_bench;

   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b1;
   logic cs_n = 1'b1;
   logic sdi = 1'b0;
   logic sdo, sdo_oe;
   logic [7:0] pwr_en;
   logic [4:0] lin_gain_r;
   logic [5:0] lout_gain_r, mix_ctrl, fmt_ctrl;
   logic [2:0] rst_ctrl;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   codec_spi_regs u_codec_spi_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_sclk    (sclk),
      .spi_cs_n    (cs_n),
      .spi_sdi     (sdi),
      .spi_sdo     (sdo),
      .spi_sdo_oe  (sdo_oe),
      .pwr_en      (pwr_en),
      .lin_gain_r  (lin_gain_r),
      .lout_gain_r (lout_gain_r),
      .mix_ctrl    (mix_ctrl),
      .fmt_ctrl    (fmt_ctrl),
      .rst_ctrl    (rst_ctrl)
   );

   typedef struct packed {
      logic [6:0] addr;
      logic [7:0] wdata;
      logic [7:0] expect_rd;
   } vec_t;

   // write, then read back: R1 R3 R5 R6
   localparam vec_t VECS [9] = '{
      '{7'h00, 8'hA5, 8'hA5},
      '{7'h02, 8'hFF, 8'h1F},
      '{7'h06, 8'hFF, 8'h3F},
      '{7'h08, 8'hC3, 8'h03},
      '{7'h0A, 8'h7E, 8'h3E},
      '{7'h10, 8'hFF, 8'h07},
      '{7'h20, 8'hFF, 8'h00},
      '{7'h7F, 8'h55, 8'h00},
      '{7'h02, 8'h0A, 8'h0A}
   };

   logic [7:0] rx;
   logic       pre_bit;
   logic       oe_mid;

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // shifts nbits of vec MSB first; captures sdo before the falls of bits 8..15
   task automatic xfer(input int nbits, input logic [31:0] vec);
      rx = '0;
      @(negedge clk);
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < nbits; i++) begin
         sdi = vec[nbits-1-i];
         wait_clk(HALF);
         if (i == 7) pre_bit = sdo;
         if (i == 8) oe_mid = sdo_oe;
         if (i >= 8 && i < 16) rx = {rx[6:0], sdo};
         sclk = 1'b0;
         wait_clk(HALF);
         sclk = 1'b1;
      end
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(HALF);
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] d);
      xfer(16, {16'h0, 1'b0, a, d});
   endtask

   task automatic rd(input logic [6:0] a);
      xfer(16, {16'h0, 1'b1, a, 8'h00});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R8: idle line released
      chk("R8 idle oe", int'(sdo_oe), 0);
      chk("R8 idle sdo", int'(sdo), 0);

      // R4: reset values via reads and outputs
      rd(7'h00); chk("R4 00h", rx, 8'h00);
      rd(7'h02); chk("R4 02h", rx, 8'h05);
      rd(7'h06); chk("R4 06h", rx, 8'h00);
      rd(7'h08); chk("R4 08h", rx, 8'h00);
      rd(7'h0A); chk("R4 0Ah", rx, 8'h02);
      rd(7'h10); chk("R4 10h", rx, 8'h00);
      chk("R4 fmt_ctrl", fmt_ctrl, 6'h02);
      chk("R4 lin_gain_r", lin_gain_r, 5'h05);

      // table walk
      foreach (VECS[k]) begin
         wr(VECS[k].addr, VECS[k].wdata);
         rd(VECS[k].addr);
         chk("R1/R3/R5/R6 readback", rx, VECS[k].expect_rd);
      end

      // R6: unmapped writes left mapped registers alone
      rd(7'h00); chk("R6 00h intact", rx, 8'hA5);

      // R9: field outputs
      chk("R9 pwr_en", pwr_en, 8'hA5);
      chk("R9 lin_gain_r", lin_gain_r, 5'h0A);
      chk("R9 lout_gain_r", lout_gain_r, 6'h3F);
      chk("R9 mix_ctrl", mix_ctrl, 6'h03);
      chk("R9 fmt_ctrl", fmt_ctrl, 6'h3E);
      chk("R9 rst_ctrl", rst_ctrl, 3'h7);

      // R2 and R8 during a read of 00h (MSB 1)
      rd(7'h00);
      chk("R2 sdo before first data rise", int'(pre_bit), 0);
      chk("R8 oe in frame", int'(oe_mid), 1);
      chk("R3 00h", rx, 8'hA5);

      // R11: second read returns the same
      rd(7'h00); chk("R11 repeat read", rx, 8'hA5);

      // R7: short frames dropped (12 and 15 clocks)
      xfer(12, {20'h0, 1'b0, 7'h00, 4'h3});
      rd(7'h00); chk("R7 12-clock frame", rx, 8'hA5);
      xfer(15, {17'h0, 1'b0, 7'h00, 7'h3C});
      rd(7'h00); chk("R7 15-clock frame", rx, 8'hA5);
      chk("R7 pwr_en", pwr_en, 8'hA5);

      // R10: 20-clock frame keeps the first data byte
      xfer(20, {12'h0, 1'b0, 7'h00, 8'h5A, 4'hF});
      rd(7'h00); chk("R10 long frame", rx, 8'h5A);

      // R9: reset register fields
      wr(7'h10, 8'h05);
      chk("R9 rst mask/conv", rst_ctrl, 3'h5);
      wr(7'h08, 8'h21);
      chk("R9 mix invert R", mix_ctrl, 6'h21);

      // R8 after the last frame
      chk("R8 final oe", int'(sdo_oe), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule